// File: doc/BRIEF.md
# Partial-Width Register Write Merger

This block is a sixteen-entry, 64-bit general-purpose register file with one write port and two read ports. It follows the operand-size rules of a 64-bit extension of a 32-bit instruction set. A write can target the low byte, the second byte, the low 16 bits, the low 32 bits or the whole register. A 32-bit write zero-extends. The narrower writes keep every bit they do not cover.

For each register the block keeps two tracking flags. One marks a separately held low slice and the other marks a separately held second byte. A read of a view wider than the separately held pieces cannot return at once. It raises a merge, holds the stall output for a fixed number of cycles, and then returns the combined value. The merge also clears the register's flags, so the next wide read is free.

The requester holds its read inputs while `stall` is high. Writes are accepted in every cycle. A write and a read to the same register in the same cycle behave as if the write came first.

Top module: `pmerge_regfile`

## Requirements
- R1: A 64-bit write (wide flag 1, any size code) stores all 64 data bits. A 32-bit write (size code 3, wide flag 0) stores data bits 31:0 and clears bits 63:32.
- R2: A low-byte write (size code 0) replaces bits 7:0 only. A 16-bit write (size code 2) replaces bits 15:0 only. In both cases the remaining bits keep their value.
- R3: A second-byte write (size code 1) places data bits 7:0 into register bits 15:8 and changes no other bit.
- R4: A read returns its view zero-extended to 64 bits. Size code 0 gives bits 7:0, code 1 gives bits 15:8, code 2 gives bits 15:0, code 3 gives bits 31:0, and wide flag 1 gives all 64 bits. A disabled read port outputs zero.
- R5: Low-byte and 16-bit writes set the low-pending flag. A second-byte write sets the high-pending flag. 32-bit and 64-bit writes clear both flags.
- R6: A 32-bit or 64-bit read of a register with either flag set stalls. A 16-bit read stalls only when high-pending is set. Byte reads never stall. A stall lasts MERGE_CYC cycles (3 by default). After it, the combined value is returned, both flags of the merged register are clear, and a repeated read does not stall.
- R7: `merge_busy` is high in the MERGE_CYC-1 cycles that follow the cycle in which a merge is requested. `stall` is high whenever `merge_busy` is high.
- R8: Both read data outputs are zero in every cycle in which `stall` is high.
- R9: A write and a read to the same register in the same cycle are forwarded. The read sees the written data and the flags as they stand after that write. A 32-bit write therefore removes a pending merge, and a low-byte write creates one.
- R10: When both ports need a merge on different registers, port A's register merges first and port B's register merges next, with `stall` held high throughout (2*MERGE_CYC cycles). When both ports need the same register, a single merge is done.
- R11: Writes are accepted during a merge. A partial write to the merging register in the merge's last cycle takes effect after the merge's flag clear, so the register needs another merge.
- R12: After reset every register reads as zero, no flag is set, and `stall` and `merge_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_sz | input | 2 | Write size code (0 low byte, 1 second byte, 2 16-bit, 3 32-bit) |
| wr_wide | input | 1 | Width override: 1 selects a 64-bit write |
| wr_data | input | 64 | Write data, aligned at bit 0 |
| ra_en | input | 1 | Read port A enable |
| ra_idx | input | 4 | Read port A register index |
| ra_sz | input | 2 | Read port A size code |
| ra_wide | input | 1 | Read port A 64-bit override |
| ra_data | output | 64 | Read port A data, zero-extended view |
| rb_en | input | 1 | Read port B enable |
| rb_idx | input | 4 | Read port B register index |
| rb_sz | input | 2 | Read port B size code |
| rb_wide | input | 1 | Read port B 64-bit override |
| rb_data | output | 64 | Read port B data, zero-extended view |
| stall | output | 1 | Reads must be held; data not valid |
| merge_busy | output | 1 | A merge is in flight |

## Verification
The cycle that needs the most care is the one where a merge completes for a register and a new write lands on that same register. The flag clear and the flag set then fall on the same edge, and the write must win. The bench provokes this directly: it raises a wide read on a low-pending register and places a second-byte write on the merge's last cycle. It then expects a second full merge and the combined value from both writes. A related overlap is a same-cycle write and read of one register. It is provoked both with a 32-bit write, which must cancel the merge, and with a byte write, which must create one. Random traffic with frequent same-index collisions is judged cycle by cycle against a bench model of the register values, flags and merge counter.

// File: rtl/pmerge_pkg.sv
package pmerge_pkg;

  localparam int unsigned XLEN = 64;

  // Access view of a register
  typedef enum logic [2:0] {
    VW_LB = 3'd0,   // bits 7:0
    VW_HB = 3'd1,   // bits 15:8
    VW_HW = 3'd2,   // bits 15:0
    VW_DW = 3'd3,   // bits 31:0
    VW_QW = 3'd4    // bits 63:0
  } view_e;

  // Per-register tracking of separately held slices
  typedef struct packed {
    logic lo;       // low slice (7:0 or 15:0) held apart
    logic hi;       // second byte held apart
  } trk_t;

  function automatic view_e view_of(input logic [1:0] sz, input logic wide);
    view_e v;
    if (wide) begin
      v = VW_QW;
    end else begin
      case (sz)
        2'd0:    v = VW_LB;
        2'd1:    v = VW_HB;
        2'd2:    v = VW_HW;
        default: v = VW_DW;
      endcase
    end
    return v;
  endfunction

  function automatic logic [XLEN-1:0] merge_write(input logic [XLEN-1:0] old,
                                                   input logic [XLEN-1:0] data,
                                                   input view_e v);
    logic [XLEN-1:0] r;
    case (v)
      VW_LB:   r = {old[XLEN-1:8], data[7:0]};
      VW_HB:   r = {old[XLEN-1:16], data[7:0], old[7:0]};
      VW_HW:   r = {old[XLEN-1:16], data[15:0]};
      VW_DW:   r = {{(XLEN-32){1'b0}}, data[31:0]};
      default: r = data;
    endcase
    return r;
  endfunction

  function automatic trk_t track_write(input trk_t old, input view_e v);
    trk_t r;
    r = old;
    case (v)
      VW_LB, VW_HW: r.lo = 1'b1;
      VW_HB:        r.hi = 1'b1;
      default:      r    = '0;
    endcase
    return r;
  endfunction

  function automatic logic wants_merge(input trk_t t, input view_e v);
    logic r;
    case (v)
      VW_DW, VW_QW: r = t.lo | t.hi;
      VW_HW:        r = t.hi;
      default:      r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] shape_read(input logic [XLEN-1:0] val,
                                                  input view_e v);
    logic [XLEN-1:0] r;
    case (v)
      VW_LB:   r = {{(XLEN-8){1'b0}}, val[7:0]};
      VW_HB:   r = {{(XLEN-8){1'b0}}, val[15:8]};
      VW_HW:   r = {{(XLEN-16){1'b0}}, val[15:0]};
      VW_DW:   r = {{(XLEN-32){1'b0}}, val[31:0]};
      default: r = val;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pmerge_bank.sv
module pmerge_bank
  import pmerge_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  view_e            wr_view,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [XLEN-1:0]  val_q [NREGS],
  output trk_t             trk_q [NREGS]
);

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic            hit, clr;
    logic [XLEN-1:0] val_r, val_d;
    trk_t            trk_r, trk_base, trk_d;

    always_comb begin
      hit      = wr_en  && (wr_idx  == IDX_W'(g));
      clr      = clr_en && (clr_idx == IDX_W'(g));
      val_d    = merge_write(val_r, wr_data, wr_view);
      trk_base = clr ? '0 : trk_r;
      // a write on the clearing edge lands after the clear
      trk_d    = hit ? track_write(trk_base, wr_view) : trk_base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_r <= '0;
      end else if (hit) begin
        val_r <= val_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trk_r <= '0;
      end else if (hit || clr) begin
        trk_r <= trk_d;
      end
    end

    assign val_q[g] = val_r;
    assign trk_q[g] = trk_r;
  end

endmodule

// File: rtl/pmerge_rdport.sv
module pmerge_rdport
  import pmerge_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int IDX_W = $clog2(NREGS)
) (
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  view_e            rd_view,
  input  logic [XLEN-1:0]  val_all [NREGS],
  input  trk_t             trk_all [NREGS],
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  view_e            wr_view,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             stall,
  output logic             need,
  output logic [XLEN-1:0]  rd_data
);

  logic            fwd;
  logic [XLEN-1:0] cur_val, eff_val;
  trk_t            cur_trk, eff_trk;

  always_comb begin
    cur_val = val_all[rd_idx];
    cur_trk = trk_all[rd_idx];
    fwd     = wr_en && (wr_idx == rd_idx);
    eff_val = fwd ? merge_write(cur_val, wr_data, wr_view) : cur_val;
    eff_trk = fwd ? track_write(cur_trk, wr_view) : cur_trk;
    need    = rd_en && wants_merge(eff_trk, rd_view);
    rd_data = (rd_en && !stall) ? shape_read(eff_val, rd_view) : '0;
  end

endmodule

// File: rtl/pmerge_seq.sv
module pmerge_seq #(
  parameter int NREGS     = 16,
  parameter int MERGE_CYC = 3,
  parameter int IDX_W     = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             need_a,
  input  logic             need_b,
  input  logic [IDX_W-1:0] idx_a,
  input  logic [IDX_W-1:0] idx_b,
  output logic             stall,
  output logic             busy,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx
);

  localparam int CNT_W = $clog2(MERGE_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             start, cnt_nz;

  always_comb begin
    cnt_nz = (cnt_q != '0);
    start  = !cnt_nz && (need_a || need_b);
    if (cnt_nz) begin
      cnt_d = cnt_q - 1'b1;
    end else if (start) begin
      cnt_d = CNT_W'(MERGE_CYC - 1);
    end else begin
      cnt_d = '0;
    end
    idx_d   = need_a ? idx_a : idx_b;
    stall   = cnt_nz || need_a || need_b;
    busy    = cnt_nz;
    clr_en  = (cnt_q == CNT_W'(1));
    clr_idx = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (start) begin
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/pmerge_regfile.sv
module pmerge_regfile
  import pmerge_pkg::*;
#(
  parameter int NREGS     = 16,
  parameter int MERGE_CYC = 3,
  localparam int IDX_W    = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_sz,
  input  logic             wr_wide,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             ra_en,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [1:0]       ra_sz,
  input  logic             ra_wide,
  output logic [XLEN-1:0]  ra_data,
  input  logic             rb_en,
  input  logic [IDX_W-1:0] rb_idx,
  input  logic [1:0]       rb_sz,
  input  logic             rb_wide,
  output logic [XLEN-1:0]  rb_data,
  output logic             stall,
  output logic             merge_busy
);

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  view_e            wr_view, ra_view, rb_view;
  logic [XLEN-1:0]  val_all [NREGS];
  trk_t             trk_all [NREGS];
  logic             need_a, need_b, clr_en;
  logic [IDX_W-1:0] clr_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  always_comb begin
    wr_view = view_of(wr_sz, wr_wide);
    ra_view = view_of(ra_sz, ra_wide);
    rb_view = view_of(rb_sz, rb_wide);
  end

  pmerge_bank #(.NREGS(NREGS), .IDX_W(IDX_W)) bank_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_view (wr_view),
    .wr_data (wr_data),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .val_q   (val_all),
    .trk_q   (trk_all)
  );

  pmerge_rdport #(.NREGS(NREGS), .IDX_W(IDX_W)) rda_i (
    .rd_en   (ra_en),
    .rd_idx  (ra_idx),
    .rd_view (ra_view),
    .val_all (val_all),
    .trk_all (trk_all),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_view (wr_view),
    .wr_data (wr_data),
    .stall   (stall),
    .need    (need_a),
    .rd_data (ra_data)
  );

  pmerge_rdport #(.NREGS(NREGS), .IDX_W(IDX_W)) rdb_i (
    .rd_en   (rb_en),
    .rd_idx  (rb_idx),
    .rd_view (rb_view),
    .val_all (val_all),
    .trk_all (trk_all),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_view (wr_view),
    .wr_data (wr_data),
    .stall   (stall),
    .need    (need_b),
    .rd_data (rb_data)
  );

  pmerge_seq #(.NREGS(NREGS), .MERGE_CYC(MERGE_CYC), .IDX_W(IDX_W)) seq_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .need_a  (need_a),
    .need_b  (need_b),
    .idx_a   (ra_idx),
    .idx_b   (rb_idx),
    .stall   (stall),
    .busy    (merge_busy),
    .clr_en  (clr_en),
    .clr_idx (clr_idx)
  );

endmodule

// File: rtl/pmerge_regfile_chk.sv
module pmerge_regfile_chk
  import pmerge_pkg::*;
#(
  parameter int NREGS     = 16,
  parameter int MERGE_CYC = 3,
  parameter int IDX_W     = $clog2(NREGS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [1:0]       wr_sz,
  input logic             wr_wide,
  input logic             ra_en,
  input logic [IDX_W-1:0] ra_idx,
  input logic [1:0]       ra_sz,
  input logic             ra_wide,
  input logic [XLEN-1:0]  ra_data,
  input logic             rb_en,
  input logic [XLEN-1:0]  rb_data,
  input logic             stall,
  input logic             merge_busy
);

  localparam int RUN_W = $clog2(MERGE_CYC + 2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (merge_busy) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  AST_STALL_ZEROES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ra_data == '0 && rb_data == '0));                           // R8

  AST_BUSY_IMPLIES_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    merge_busy |-> stall);                                                 // R7

  AST_REQ_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !merge_busy) |=> merge_busy);                                // R7

  AST_MERGE_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!merge_busy && run_q != '0) |-> (run_q == RUN_W'(MERGE_CYC - 1)));    // R6

  AST_BYTE_READ_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_en && !ra_wide && (ra_sz == 2'd0 || ra_sz == 2'd1) && !rb_en && !merge_busy)
      |-> !stall);                                                         // R6

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ra_en && !rb_en && !merge_busy) |-> !stall);                         // R6

  AST_FULL_WRITE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_wide || wr_sz == 2'd3) && ra_en && ra_idx == wr_idx &&
     !rb_en && !merge_busy) |-> !stall);                                   // R9

endmodule

bind pmerge_regfile pmerge_regfile_chk #(
  .NREGS(NREGS), .MERGE_CYC(MERGE_CYC), .IDX_W(IDX_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_sz      (wr_sz),
  .wr_wide    (wr_wide),
  .ra_en      (ra_en),
  .ra_idx     (ra_idx),
  .ra_sz      (ra_sz),
  .ra_wide    (ra_wide),
  .ra_data    (ra_data),
  .rb_en      (rb_en),
  .rb_data    (rb_data),
  .stall      (stall),
  .merge_busy (merge_busy)
);

// File: tb/pmerge_regfile_tb_top.sv
module pmerge_regfile_tb_top;

  localparam int NR = 16;
  localparam int MC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_wide = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [1:0]  wr_sz = '0;
  logic [63:0] wr_data = '0;
  logic        ra_en = 1'b0, ra_wide = 1'b0, rb_en = 1'b0, rb_wide = 1'b0;
  logic [3:0]  ra_idx = '0, rb_idx = '0;
  logic [1:0]  ra_sz = '0, rb_sz = '0;
  logic [63:0] ra_data, rb_data;
  logic        stall, merge_busy;

  always #5 clk = ~clk;

  pmerge_regfile #(.NREGS(NR), .MERGE_CYC(MC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sz(wr_sz), .wr_wide(wr_wide), .wr_data(wr_data),
    .ra_en(ra_en), .ra_idx(ra_idx), .ra_sz(ra_sz), .ra_wide(ra_wide), .ra_data(ra_data),
    .rb_en(rb_en), .rb_idx(rb_idx), .rb_sz(rb_sz), .rb_wide(rb_wide), .rb_data(rb_data),
    .stall(stall), .merge_busy(merge_busy)
  );

  // bench model
  logic [63:0] m_val [NR];
  bit          m_lo [NR];
  bit          m_hi [NR];
  int          m_cnt = 0;
  int          m_idx = 0;
  int          n_chk = 0;
  int          n_err = 0;
  bit          obs_stall;
  logic [63:0] obs_a, obs_b;

  function automatic int vcode(input logic [1:0] sz, input logic wide);
    return wide ? 4 : int'(sz);
  endfunction

  function automatic logic [63:0] fold(input logic [63:0] old, input logic [63:0] d, input int v);
    case (v)
      0: return {old[63:8], d[7:0]};
      1: return {old[63:16], d[7:0], old[7:0]};
      2: return {old[63:16], d[15:0]};
      3: return {32'h0, d[31:0]};
      default: return d;
    endcase
  endfunction

  function automatic bit needs(input bit lo, input bit hi, input int v);
    if (v >= 3) return lo | hi;
    if (v == 2) return hi;
    return 1'b0;
  endfunction

  function automatic logic [63:0] view(input logic [63:0] x, input int v);
    case (v)
      0: return {56'h0, x[7:0]};
      1: return {56'h0, x[15:8]};
      2: return {48'h0, x[15:0]};
      3: return {32'h0, x[31:0]};
      default: return x;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic peek(input logic [3:0] idx, output logic [63:0] v, output bit lo, output bit hi);
    int wv;
    v  = m_val[idx];
    lo = m_lo[idx];
    hi = m_hi[idx];
    wv = vcode(wr_sz, wr_wide);
    if (wr_en && wr_idx == idx) begin
      v = fold(v, wr_data, wv);
      if (wv == 0 || wv == 2) lo = 1'b1;
      else if (wv == 1) hi = 1'b1;
      else begin lo = 1'b0; hi = 1'b0; end
    end
  endtask

  // one cycle: inputs already set in the low phase
  task automatic run(input string tag);
    logic [63:0] va, vb, ea, eb;
    bit la, ha, lb, hb, na, nb, es;
    int wv;
    #1;
    peek(ra_idx, va, la, ha);
    peek(rb_idx, vb, lb, hb);
    na = ra_en && needs(la, ha, vcode(ra_sz, ra_wide));
    nb = rb_en && needs(lb, hb, vcode(rb_sz, rb_wide));
    es = (m_cnt != 0) || na || nb;
    ea = (ra_en && !es) ? view(va, vcode(ra_sz, ra_wide)) : 64'h0;
    eb = (rb_en && !es) ? view(vb, vcode(rb_sz, rb_wide)) : 64'h0;
    check("R6", "stall", {63'h0, stall}, {63'h0, es});
    check("R7", "merge_busy", {63'h0, merge_busy}, {63'h0, m_cnt != 0});
    check(es ? "R8" : tag, "ra_data", ra_data, ea);
    check(es ? "R8" : tag, "rb_data", rb_data, eb);
    obs_stall = stall;
    obs_a = ra_data;
    obs_b = rb_data;
    @(posedge clk);
    if (m_cnt == 1) begin
      m_lo[m_idx] = 1'b0;
      m_hi[m_idx] = 1'b0;
    end
    if (m_cnt != 0) m_cnt--;
    else if (na || nb) begin
      m_cnt = MC - 1;
      m_idx = na ? int'(ra_idx) : int'(rb_idx);
    end
    if (wr_en) begin
      wv = vcode(wr_sz, wr_wide);
      m_val[wr_idx] = fold(m_val[wr_idx], wr_data, wv);
      if (wv == 0 || wv == 2) m_lo[wr_idx] = 1'b1;
      else if (wv == 1) m_hi[wr_idx] = 1'b1;
      else begin m_lo[wr_idx] = 1'b0; m_hi[wr_idx] = 1'b0; end
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] i, input logic [1:0] sz, input logic w, input logic [63:0] d);
    wr_en = 1'b1; wr_idx = i; wr_sz = sz; wr_wide = w; wr_data = d;
    ra_en = 1'b0; rb_en = 1'b0;
    run("R1");
    wr_en = 1'b0;
  endtask

  task automatic rda(input logic [3:0] i, input logic [1:0] sz, input logic w);
    ra_en = 1'b1; ra_idx = i; ra_sz = sz; ra_wide = w;
  endtask

  task automatic rdb(input logic [3:0] i, input logic [1:0] sz, input logic w);
    rb_en = 1'b1; rb_idx = i; rb_sz = sz; rb_wide = w;
  endtask

  // hold the current reads until the stall drops
  task automatic hold(input string tag, input int exp_cyc, input logic [63:0] exp_a);
    int n = 0;
    run(tag);
    while (obs_stall && n < 20) begin
      n++;
      run(tag);
    end
    check(tag, "stall cycles", 64'(n), 64'(exp_cyc));
    check(tag, "held data", obs_a, exp_a);
    ra_en = 1'b0; rb_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NR; i++) begin
      m_val[i] = '0; m_lo[i] = 1'b0; m_hi[i] = 1'b0;
    end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12: reset state
    for (int i = 0; i < NR; i++) begin
      rda(4'(i), 2'd0, 1'b1);
      rdb(4'(i), 2'd3, 1'b0);
      run("R12");
      check("R12", "reset ra", obs_a, 64'h0);
      check("R12", "reset stall", {63'h0, obs_stall}, 64'h0);
    end
    ra_en = 1'b0; rb_en = 1'b0;

    // R1: full and zero-extending writes
    wr(4'd1, 2'd0, 1'b1, 64'h1122_3344_5566_7788);
    rda(4'd1, 2'd0, 1'b1); hold("R1", 0, 64'h1122_3344_5566_7788);
    wr(4'd1, 2'd3, 1'b0, 64'hFFFF_FFFF_AABB_CCDD);
    rda(4'd1, 2'd0, 1'b1); hold("R1", 0, 64'h0000_0000_AABB_CCDD);

    // R2 / R6: low byte then 16-bit write, wide reads merge
    wr(4'd2, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(4'd2, 2'd0, 1'b0, 64'h0000_0000_0000_015A);
    rda(4'd2, 2'd0, 1'b1); hold("R2", MC, 64'hFFFF_FFFF_FFFF_FF5A);
    rda(4'd2, 2'd0, 1'b1); hold("R5", 0, 64'hFFFF_FFFF_FFFF_FF5A);
    wr(4'd2, 2'd2, 1'b0, 64'h0000_0000_0012_BEEF);
    rda(4'd2, 2'd3, 1'b0); hold("R2", MC, 64'h0000_0000_FFFF_BEEF);

    // R3 / R4: second byte write and the narrow views
    wr(4'd3, 2'd0, 1'b1, 64'h0102_0304_0506_0708);
    wr(4'd3, 2'd1, 1'b0, 64'h0000_0000_0000_77C3);
    rda(4'd3, 2'd1, 1'b0); hold("R4", 0, 64'h0000_0000_0000_00C3);
    rda(4'd3, 2'd0, 1'b0); hold("R4", 0, 64'h0000_0000_0000_0008);
    rda(4'd3, 2'd2, 1'b0); hold("R3", MC, 64'h0000_0000_0000_C308);
    rda(4'd3, 2'd0, 1'b1); hold("R3", 0, 64'h0102_0304_0506_C308);

    // R5 / R6: low pending only, 16-bit read free, wide read merges
    wr(4'd4, 2'd3, 1'b0, 64'h0);
    wr(4'd4, 2'd0, 1'b0, 64'h11);
    rda(4'd4, 2'd2, 1'b0); hold("R6", 0, 64'h11);
    rda(4'd4, 2'd0, 1'b1); hold("R5", MC, 64'h11);

    // R9: same-cycle forwarding
    wr(4'd5, 2'd0, 1'b1, 64'hAAAA_AAAA_AAAA_AAAA);
    wr(4'd5, 2'd0, 1'b0, 64'h01);
    wr_en = 1'b1; wr_idx = 4'd5; wr_sz = 2'd3; wr_wide = 1'b0; wr_data = 64'h9999_0000_1234_5678;
    rda(4'd5, 2'd0, 1'b1);
    run("R9");
    check("R9", "fwd 32-bit no stall", {63'h0, obs_stall}, 64'h0);
    check("R9", "fwd data", obs_a, 64'h0000_0000_1234_5678);
    wr_en = 1'b0; ra_en = 1'b0;
    wr(4'd6, 2'd0, 1'b1, 64'h5);
    wr_en = 1'b1; wr_idx = 4'd6; wr_sz = 2'd0; wr_wide = 1'b0; wr_data = 64'h77;
    rda(4'd6, 2'd0, 1'b1);
    run("R9");
    check("R9", "fwd byte stalls", {63'h0, obs_stall}, 64'h1);
    wr_en = 1'b0;
    hold("R9", MC - 1, 64'h77);

    // R10: both ports merge, different then same register
    wr(4'd7, 2'd3, 1'b0, 64'h7070);
    wr(4'd7, 2'd0, 1'b0, 64'h99);
    wr(4'd8, 2'd3, 1'b0, 64'h8080);
    wr(4'd8, 2'd1, 1'b0, 64'h11);
    rda(4'd7, 2'd0, 1'b1); rdb(4'd8, 2'd3, 1'b0);
    hold("R10", 2 * MC, 64'h7099);
    check("R10", "port b data", obs_b, 64'h1180);
    wr(4'd9, 2'd1, 1'b0, 64'h42);
    rda(4'd9, 2'd0, 1'b1); rdb(4'd9, 2'd3, 1'b0);
    hold("R10", MC, 64'h4200);

    // R11: write to the merging register on the merge's last cycle
    wr(4'd10, 2'd3, 1'b0, 64'hA0A0);
    wr(4'd10, 2'd0, 1'b0, 64'h01);
    rda(4'd10, 2'd0, 1'b1);
    for (int k = 0; k < MC - 1; k++) run("R11");
    wr_en = 1'b1; wr_idx = 4'd10; wr_sz = 2'd1; wr_wide = 1'b0; wr_data = 64'h55;
    run("R11");
    wr_en = 1'b0;
    hold("R11", MC, 64'h5501);

    // constrained random traffic
    for (int c = 0; c < 4000; c++) begin
      wr_en   = ($urandom % 2) == 0;
      wr_idx  = 4'($urandom % 4);
      wr_sz   = 2'($urandom);
      wr_wide = ($urandom % 4) == 0;
      wr_data = {$urandom, $urandom};
      if (!(obs_stall && ($urandom % 4) != 0)) begin
        ra_en = ($urandom % 10) < 7; ra_idx = 4'($urandom % 4);
        ra_sz = 2'($urandom); ra_wide = ($urandom % 3) == 0;
        rb_en = ($urandom % 10) < 5; rb_idx = 4'($urandom % 4);
        rb_sz = 2'($urandom); rb_wide = ($urandom % 3) == 0;
      end
      run("R4");
    end

    finish_run();
  end

endmodule